// File: doc/BRIEF.md
# Label-Driven Message Sequencer

The block runs a small byte-code program held in a constant ROM and sends the characters of its messages, one byte at a time, over a valid/ready transmit handshake. The usual consumer is a UART transmitter. The program can do the following:

- print text;
- jump to an absolute byte address;
- jump through a label table;
- pause for a counted number of delay units;
- halt;
- park until an external label selector changes, then resume at that label.

The label table maps each label number to the address of its label marker. It is computed from the program contents when the design is elaborated, so at run time it is only a lookup. The scan follows instruction lengths, so message text and operand bytes are never taken for label markers. A label number that is defined twice stops elaboration.

A typical program prints a message for each label and then parks at a wait instruction. The host selects a message by driving a new value on the label selector.

Top module: `msgseq_engine`

## Requirements
- R1: While reset is high, the program counter returns to address 0, `tx_valid` and `halted` go low, and the current `tgt_label` value is captured as the last-served label. After reset, execution starts at byte 0.
- R2: A message instruction (opcode 0xF1) sends every following byte, in address order, until an end byte (0x00). The end byte is not sent.
- R3: A byte is offered with `tx_valid` high and is taken on a clock edge where `tx_ready` is high. While not taken, `tx_valid` and `tx_data` stay unchanged.
- R4: A direct jump (opcode 0xF2 followed by one address byte) continues at that address. Bytes between the jump and its target are never executed.
- R5: A label marker (opcode 176 followed by one label-number byte) has no effect when executed. Execution continues two bytes later.
- R6: A table jump (opcode 0xF3 followed by one label-number byte) continues at the address of that label's marker.
- R7: A delay instruction (opcode 0xF4 followed by a count byte n) waits n × `UNIT_CYCLES` clocks before the next fetch. A count of 0 adds no wait.
- R8: A wait instruction (opcode 0xF5) stalls while `tgt_label` equals the last-served label. When they differ, the engine stores the new value and jumps to that label's marker. A change made before the wait is reached releases it at once. An unchanged value never releases it.
- R9: A halt instruction (opcode 0xF0) sets `halted` and stops execution until reset. While halted, nothing is sent and `tgt_label` changes are ignored.
- R10: The label table holds, for each label number, the address of its marker. It is built at elaboration by an opcode-aware scan, and a repeated label number makes elaboration fail.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tgt_label | input | LBL_W | External label selector for wait instructions |
| tx_ready | input | 1 | Transmitter can take a byte |
| tx_valid | output | 1 | A message byte is offered |
| tx_data | output | 8 | Offered message byte |
| halted | output | 1 | A halt instruction has been executed |

## Verification
The two functions that can land on the same clock edge are a change of the label selector and a character handshake in the middle of a message. The bench forces this by changing `tgt_label` on the edge where the first character of a message is accepted, while `tx_ready` toggles in a fixed pseudo-random pattern. Expected behaviour: the current message finishes intact and the next wait releases immediately to the new label. The scoreboard judges this by the order of the bytes it receives, and by the absence of any extra or repeated byte.

// File: rtl/msgseq_pkg.sv
package msgseq_pkg;

  localparam logic [7:0] OP_EOM   = 8'h00;
  localparam logic [7:0] OP_LABEL = 8'd176;
  localparam logic [7:0] OP_HALT  = 8'hF0;
  localparam logic [7:0] OP_MSG   = 8'hF1;
  localparam logic [7:0] OP_GOTO  = 8'hF2;
  localparam logic [7:0] OP_GOTOL = 8'hF3;
  localparam logic [7:0] OP_DELAY = 8'hF4;
  localparam logic [7:0] OP_WAITL = 8'hF5;

  localparam int DEF_DEPTH = 64;

  typedef enum logic [3:0] {
    ST_FETCH, ST_OP, ST_ARG_RD, ST_ARG, ST_CHR_RD,
    ST_CHR, ST_SEND, ST_DELAY, ST_WAIT, ST_HALT
  } seq_state_t;

  // Demonstration program; labels: 0->0, 1->25, 2->18, 3->32
  function automatic logic [8*DEF_DEPTH-1:0] default_program();
    logic [7:0] b [DEF_DEPTH];
    logic [8*DEF_DEPTH-1:0] p;
    for (int i = 0; i < DEF_DEPTH; i++) b[i] = OP_EOM;
    b[0]  = OP_LABEL; b[1]  = 8'd0;
    b[2]  = OP_MSG;   b[3]  = "H";  b[4]  = "i";  b[5]  = OP_EOM;
    b[6]  = OP_DELAY; b[7]  = 8'd0;
    b[8]  = OP_GOTO;  b[9]  = 8'd13;
    b[10] = OP_MSG;   b[11] = "Z";  b[12] = OP_EOM;
    b[13] = OP_DELAY; b[14] = 8'd3;
    b[15] = OP_GOTOL; b[16] = 8'd2;
    b[17] = OP_HALT;
    b[18] = OP_LABEL; b[19] = 8'd2;
    b[20] = OP_MSG;   b[21] = "L";  b[22] = "B";  b[23] = OP_EOM;
    b[24] = OP_WAITL;
    b[25] = OP_LABEL; b[26] = 8'd1;
    b[27] = OP_MSG;   b[28] = "O";  b[29] = "K";  b[30] = OP_EOM;
    b[31] = OP_WAITL;
    b[32] = OP_LABEL; b[33] = 8'd3;
    b[34] = OP_DELAY; b[35] = 8'd176;
    b[36] = OP_HALT;
    for (int i = 0; i < DEF_DEPTH; i++) p[8*i +: 8] = b[i];
    return p;
  endfunction

endpackage

// File: rtl/msgseq_rom.sv
module msgseq_rom #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter logic [8*DEPTH-1:0] CONTENT = '0
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [7:0]    q
);
  // Synchronous read so the constant store maps onto block memory
  always_ff @(posedge clk) begin
    q <= CONTENT[8*int'(addr) +: 8];
  end
endmodule

// File: rtl/msgseq_lbl_table.sv
module msgseq_lbl_table
  import msgseq_pkg::*;
#(
  parameter int PROG_DEPTH = 64,
  parameter int PC_W       = 6,
  parameter int LBL_W      = 2,
  parameter logic [8*PROG_DEPTH-1:0] PROGRAM = '0
) (
  input  logic [LBL_W-1:0] lbl_i,
  output logic [PC_W-1:0]  addr_o
);
  localparam int NUM_LBL = 1 << LBL_W;

  // Walks the program by instruction length: text and operands are skipped
  function automatic logic [NUM_LBL*PC_W-1:0] build_table();
    logic [NUM_LBL*PC_W-1:0] t;
    int skip;
    bit in_msg;
    logic [7:0] b, nb;
    int j;
    t = '0; skip = 0; in_msg = 1'b0;
    for (int i = 0; i < PROG_DEPTH; i++) begin
      b  = PROGRAM[8*i +: 8];
      j  = (i + 1 < PROG_DEPTH) ? i + 1 : i;
      nb = PROGRAM[8*j +: 8];
      if (skip > 0) skip = skip - 1;
      else if (in_msg) begin
        if (b == OP_EOM) in_msg = 1'b0;
      end else begin
        case (b)
          OP_MSG:   in_msg = 1'b1;
          OP_LABEL: begin
            t[int'(nb[LBL_W-1:0])*PC_W +: PC_W] = PC_W'(i);
            skip = 1;
          end
          OP_GOTO, OP_GOTOL, OP_DELAY: skip = 1;
          default: ;
        endcase
      end
    end
    return t;
  endfunction

  function automatic int count_dups();
    logic [NUM_LBL-1:0] seen;
    int skip, dups;
    bit in_msg;
    logic [7:0] b, nb;
    int j;
    seen = '0; skip = 0; dups = 0; in_msg = 1'b0;
    for (int i = 0; i < PROG_DEPTH; i++) begin
      b  = PROGRAM[8*i +: 8];
      j  = (i + 1 < PROG_DEPTH) ? i + 1 : i;
      nb = PROGRAM[8*j +: 8];
      if (skip > 0) skip = skip - 1;
      else if (in_msg) begin
        if (b == OP_EOM) in_msg = 1'b0;
      end else begin
        case (b)
          OP_MSG:   in_msg = 1'b1;
          OP_LABEL: begin
            if (seen[nb[LBL_W-1:0]]) dups = dups + 1;
            seen[nb[LBL_W-1:0]] = 1'b1;
            skip = 1;
          end
          OP_GOTO, OP_GOTOL, OP_DELAY: skip = 1;
          default: ;
        endcase
      end
    end
    return dups;
  endfunction

  localparam logic [NUM_LBL*PC_W-1:0] TABLE = build_table();
  localparam int DUPS = count_dups();

  // R10: a repeated label number stops elaboration
  generate
    if (DUPS != 0) begin : g_dup_label
      $error("msgseq_lbl_table: label number defined more than once");
    end
  endgenerate

  assign addr_o = TABLE[int'(lbl_i)*PC_W +: PC_W];
endmodule

// File: rtl/msgseq_delay.sv
module msgseq_delay #(
  parameter int UNIT_CYCLES = 4,
  parameter int CNT_W       = 11
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] units,
  output logic       last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= CNT_W'(units) * CNT_W'(UNIT_CYCLES);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign last = (cnt == CNT_W'(1));
endmodule

// File: rtl/msgseq_engine.sv
module msgseq_engine
  import msgseq_pkg::*;
#(
  parameter int PROG_DEPTH  = DEF_DEPTH,
  parameter int LBL_W       = 2,
  parameter int UNIT_CYCLES = 4,
  parameter logic [8*PROG_DEPTH-1:0] PROGRAM = default_program()
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LBL_W-1:0] tgt_label,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             halted
);
  localparam int PC_W  = $clog2(PROG_DEPTH);
  localparam int CNT_W = 8 + $clog2(UNIT_CYCLES + 1);
  localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

  seq_state_t       state;
  logic [PC_W-1:0]  pc, pc_inc, lut_addr;
  logic [7:0]       rom_q, op;
  logic [LBL_W-1:0] seen_lbl, lut_idx;
  logic             dly_load, dly_last;

  assign pc_inc   = pc + PC_ONE;
  assign lut_idx  = (state == ST_WAIT) ? tgt_label : rom_q[LBL_W-1:0];
  assign dly_load = (state == ST_ARG) && (op == OP_DELAY);

  msgseq_rom #(.DEPTH(PROG_DEPTH), .AW(PC_W), .CONTENT(PROGRAM)) u_rom (
    .clk(clk), .addr(pc), .q(rom_q)
  );

  msgseq_lbl_table #(.PROG_DEPTH(PROG_DEPTH), .PC_W(PC_W), .LBL_W(LBL_W),
                     .PROGRAM(PROGRAM)) u_lbl (
    .lbl_i(lut_idx), .addr_o(lut_addr)
  );

  msgseq_delay #(.UNIT_CYCLES(UNIT_CYCLES), .CNT_W(CNT_W)) u_dly (
    .clk(clk), .rst(rst), .load(dly_load), .units(rom_q), .last(dly_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_FETCH;
      pc       <= '0;
      op       <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
      halted   <= 1'b0;
      seen_lbl <= tgt_label;
    end else begin
      unique case (state)
        ST_FETCH: state <= ST_OP;
        ST_OP: begin
          op <= rom_q;
          case (rom_q)
            OP_MSG: begin pc <= pc_inc; state <= ST_CHR_RD; end
            OP_GOTO, OP_GOTOL, OP_LABEL, OP_DELAY: begin
              pc <= pc_inc; state <= ST_ARG_RD;
            end
            OP_HALT:  begin halted <= 1'b1; state <= ST_HALT; end
            OP_WAITL: state <= ST_WAIT;
            default:  begin pc <= pc_inc; state <= ST_FETCH; end
          endcase
        end
        ST_ARG_RD: state <= ST_ARG;
        ST_ARG: begin
          state <= ST_FETCH;
          case (op)
            OP_GOTO:  pc <= rom_q[PC_W-1:0];
            OP_GOTOL: pc <= lut_addr;
            OP_DELAY: begin
              pc <= pc_inc;
              if (rom_q != 8'd0) state <= ST_DELAY;
            end
            default:  pc <= pc_inc;
          endcase
        end
        ST_CHR_RD: state <= ST_CHR;
        ST_CHR: begin
          if (rom_q == OP_EOM) begin
            pc    <= pc_inc;
            state <= ST_FETCH;
          end else begin
            tx_valid <= 1'b1;
            tx_data  <= rom_q;
            state    <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (tx_ready) begin
            tx_valid <= 1'b0;
            pc       <= pc_inc;
            state    <= ST_CHR_RD;
          end
        end
        ST_DELAY: if (dly_last) state <= ST_FETCH;
        ST_WAIT: begin
          if (tgt_label != seen_lbl) begin
            seen_lbl <= tgt_label;
            pc       <= lut_addr;
            state    <= ST_FETCH;
          end
        end
        ST_HALT: ;
        default: state <= ST_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/msgseq_engine_chk.sv
module msgseq_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       halted
);
  a_r3_hold_offer: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  a_r2_no_end_byte: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> tx_data != 8'h00);

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  a_r9_silent_halt: assert property (@(posedge clk) disable iff (rst)
    halted |-> !tx_valid);

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !tx_valid && !halted);
endmodule

bind msgseq_engine msgseq_engine_chk u_chk (
  .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .halted(halted)
);

// File: tb/sim_msgseq_engine.sv
`timescale 1ns/1ps
module sim_msgseq_engine;
  localparam int UNIT = 4;
  localparam int GAP  = 26 + 3*UNIT;  // 'i' accept edge to 'L' offer edge

  logic       clk = 1'b0, rst = 1'b1, rdy = 1'b1, bp_en = 1'b0;
  logic [1:0] tgt = 2'd0;
  logic       tx_valid, halted;
  logic [7:0] tx_data;

  int n_chk = 0, n_fail = 0, cyc = 0, sent = 0, acc_i = -1;
  bit seen_l = 1'b0, saw_z = 1'b0, stall_prev = 1'b0;
  logic [7:0] stall_data;
  logic [7:0] expq[$];
  string      tagq[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  msgseq_engine #(.UNIT_CYCLES(UNIT)) u0 (
    .clk(clk), .rst(rst), .tgt_label(tgt), .tx_ready(rdy),
    .tx_valid(tx_valid), .tx_data(tx_data), .halted(halted)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_str(string s, string req);
    for (int k = 0; k < s.len(); k++) begin
      expq.push_back(s[k]);
      tagq.push_back(req);
    end
  endtask

  task automatic drain(string req);
    int n = 0;
    while (expq.size() != 0 && n < 4000) begin
      @(negedge clk); n++;
    end
    check(expq.size() == 0, req, "bytes still missing", expq.size(), 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // ready driver: fixed pseudo-random backpressure pattern
  initial begin
    logic [7:0] lfsr = 8'hA5;
    forever begin
      @(posedge clk); #1;
      if (bp_en) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        rdy  = lfsr[0] | lfsr[2];
      end else rdy = 1'b1;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (stall_prev)  // R3
        check(tx_valid && tx_data == stall_data, "R3", "held byte", tx_data, stall_data);
      stall_prev = tx_valid && !rdy;
      stall_data = tx_data;
      if (tx_valid && !seen_l && tx_data == "L") begin
        seen_l = 1'b1;
        check(cyc - acc_i == GAP, "R7", "delay gap cycles", cyc - acc_i, GAP);
      end
      if (tx_valid && rdy) begin
        sent++;
        if (tx_data == "Z") saw_z = 1'b1;
        if (tx_data == "i" && acc_i < 0) acc_i = cyc + 1;
        if (expq.size() == 0)
          check(1'b0, "R8", "unexpected byte", tx_data, 0);
        else begin
          automatic logic [7:0] e = expq.pop_front();
          automatic string t = tagq.pop_front();
          check(tx_data == e, t, "byte", tx_data, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run timed out", 0, 1);
    finish_run();
  end

  initial begin
    int snap, n;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(tx_valid == 1'b0, "R1", "tx_valid in reset", tx_valid, 0);
    check(halted == 1'b0, "R1", "halted in reset", halted, 0);
    expect_str("Hi", "R2");  // R1: starts at byte 0
    expect_str("LB", "R6");
    @(posedge clk); #1 rst = 1'b0;
    drain("R6");
    snap = sent;
    repeat (60) @(negedge clk);
    check(sent == snap, "R8", "unchanged label released wait", sent - snap, 0);

    bp_en = 1'b1;
    expect_str("OK", "R8");
    expect_str("LB", "R8");  // change made during the message
    tgt = 2'd1;
    n = 0;
    while (!(tx_valid && tx_data == "O") && n < 2000) begin
      @(negedge clk); n++;
    end
    tgt = 2'd2;
    drain("R8");
    repeat (60) @(negedge clk);

    expect_str("Hi", "R10");
    expect_str("LB", "R5");
    tgt = 2'd0;
    drain("R5");
    repeat (60) @(negedge clk);

    tgt = 2'd3;
    n = 0;
    while (!halted && n < 2000) begin
      @(negedge clk); n++;
    end
    check(halted == 1'b1, "R9", "halted after halt opcode", halted, 1);
    snap = sent;
    tgt = 2'd1;
    repeat (80) @(negedge clk);
    check(halted == 1'b1, "R9", "halted stays set", halted, 1);
    check(sent == snap, "R9", "bytes sent while halted", sent - snap, 0);
    check(!saw_z, "R4", "skipped message printed", saw_z, 0);
    check(sent == 12, "R5", "total bytes sent", sent, 12);
    finish_run();
  end
endmodule